// File: doc/BRIEF.md
# Serial Offset Frequency Loader

This block takes a frequency offset word that arrives one bit per clock on a serial data line, with a separate sync line marking where each word begins. It assembles the word and hands it to a phase accumulator's frequency register as a full-width offset, together with a single-cycle load strobe. It does not contain the accumulator, the sine/cosine lookup or any clock-domain crossing.

A word starts when the sync line is sampled high. The data bit sampled on that same edge is not part of the word. The most significant bit is sampled on the next edge, and the rest follow one per clock. A two-bit length select gives the word length: 8, 16, 24 or 32 bits. A shorter word is placed at the top of the 32-bit offset, and the bits below it are zero. If sync is sampled high again while a word is still arriving, that word is dropped and reception starts over.

The controller is a three-state machine. IDLE waits for sync. RECV counts the incoming bits. PUBLISH lasts one cycle and commits the finished word. The transitions are:
- IDLE to RECV on sync (start).
- RECV to RECV on sync (abort and restart).
- RECV to RECV while bits remain (shift).
- RECV to PUBLISH on the last bit (complete).
- PUBLISH to IDLE without sync (return).
- PUBLISH to RECV with sync (chain).

Top module: `offset_word_loader`

## Requirements
- R1: While reset is asserted and after it is released, `ofs_load` is 0 and `ofs_word` is all zeros until the first word completes.
- R2: When `ser_sync` is sampled high on an edge, a new word starts. The `ser_data` value sampled on that edge is ignored. The word's most significant bit is sampled on the following edge.
- R3: `len_sel` is sampled on the edge where `ser_sync` is sampled high. The encoding is 00 = 8 bits, 01 = 16 bits, 10 = 24 bits, 11 = 32 bits. Changes to `len_sel` at any other time have no effect on the word being received.
- R4: Bits are taken most significant first. A word of N bits is published with its first bit at `ofs_word[31]` and its last bit at `ofs_word[32-N]`. Bits `ofs_word[31-N:0]` are zero.
- R5: Sync is sampled on edge E and the last of N bits on edge E+N. `ofs_load` goes high after edge E+N+1, stays high for exactly one cycle, and `ofs_word` carries the new word in that cycle.
- R6: `ofs_word` changes only on a cycle in which `ofs_load` is high. Data sampled while no word is in progress is ignored.
- R7: If `ser_sync` is sampled high while a word is being received, including on the edge that would take its last bit, that word is never published and reception restarts under R2.
- R8: If `ser_sync` is sampled high in the cycle after a word's last bit, that word is still published under R5, and the next word starts under R2 with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| len_sel | input | 2 | Word length select (00=8, 01=16, 10=24, 11=32 bits) |
| ser_data | input | 1 | Serial offset data, most significant bit first |
| ser_sync | input | 1 | Word start marker, high one clock before the first bit |
| ofs_word | output | 32 | Left-aligned offset word for the frequency register |
| ofs_load | output | 1 | One-cycle strobe marking a newly published `ofs_word` |

## Verification
Suppose sync is sampled on edge E and the word is N bits long. Its bits are sampled on edges E+1 to E+N, the machine is in PUBLISH after E+N, and `ofs_load` with the new `ofs_word` appears after E+N+1. After that edge the output holds until the next publish. The bench drives inputs on falling edges and counts its own falling edges. When it sends the last bit it schedules the expected strobe exactly two falling edges later. On every other falling edge it requires the strobe low and the word equal to the last value published. This catches strobes that arrive late, early, twice, or for aborted words. Chained words, aborts in mid-word and on the final bit, and random length selects changing during reception are mixed with constrained-random traffic.

// File: rtl/ofl_pkg.sv
`timescale 1ns/1ps
package ofl_pkg;

    // Controller states of the serial offset loader.
    typedef enum logic [1:0] {
        OFL_IDLE    = 2'd0,
        OFL_RECV    = 2'd1,
        OFL_PUBLISH = 2'd2
    } ofl_state_e;

    // Default word-length granularity and width of the length select.
    localparam int unsigned OFL_UNIT_W_DEF = 8;
    localparam int unsigned OFL_SEL_W_DEF  = 2;

endpackage

// File: rtl/ofl_ctrl.sv
`timescale 1ns/1ps
module ofl_ctrl
    import ofl_pkg::*;
#(
    parameter int unsigned UNIT_W = OFL_UNIT_W_DEF,
    parameter int unsigned SEL_W  = OFL_SEL_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic [SEL_W-1:0] len_sel_i,
    output logic             clr_o,
    output logic             cap_o,
    output logic             pub_o,
    output logic [SEL_W-1:0] len_o
);

    localparam int unsigned OFS_W = UNIT_W * (2 ** SEL_W);
    localparam int unsigned CNT_W = $clog2(OFS_W);

    ofl_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [SEL_W-1:0] len_q, len_d;
    logic [CNT_W-1:0] last_idx;

    // Index of the final bit for the latched length.
    assign last_idx = CNT_W'((int'(len_q) + 1) * int'(UNIT_W) - 1);
    assign len_o    = len_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OFL_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            len_q   <= len_d;
        end
    end

    // Next state and control outputs.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        len_d   = len_q;
        clr_o   = 1'b0;
        cap_o   = 1'b0;
        pub_o   = 1'b0;
        unique case (state_q)
            OFL_IDLE: begin
                if (sync_i) begin
                    state_d = OFL_RECV;
                    cnt_d   = '0;
                    len_d   = len_sel_i;
                    clr_o   = 1'b1;
                end
            end
            OFL_RECV: begin
                if (sync_i) begin
                    state_d = OFL_RECV;
                    cnt_d   = '0;
                    len_d   = len_sel_i;
                    clr_o   = 1'b1;
                end else begin
                    cap_o = 1'b1;
                    if (cnt_q == last_idx) begin
                        state_d = OFL_PUBLISH;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            OFL_PUBLISH: begin
                pub_o = 1'b1;
                if (sync_i) begin
                    state_d = OFL_RECV;
                    cnt_d   = '0;
                    len_d   = len_sel_i;
                    clr_o   = 1'b1;
                end else begin
                    state_d = OFL_IDLE;
                end
            end
            default: begin
                state_d = OFL_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    AST_SYNC_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (state_q == OFL_RECV && cnt_q == '0)); // R7

    AST_IDLE_IGNORES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OFL_IDLE && !sync_i) |=> (state_q == OFL_IDLE)); // R6

    AST_PUBLISH_AFTER_RECV: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OFL_PUBLISH) |-> ($past(state_q) == OFL_RECV)); // R5

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OFL_RECV) |-> (cnt_q <= last_idx)); // R3

endmodule

// File: rtl/ofl_shift.sv
`timescale 1ns/1ps
module ofl_shift #(
    parameter int unsigned UNIT_W = 8,
    parameter int unsigned SEL_W  = 2,
    parameter int unsigned OFS_W  = UNIT_W * (2 ** SEL_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             cap_i,
    input  logic             bit_i,
    input  logic [SEL_W-1:0] len_i,
    output logic [OFS_W-1:0] aligned_o
);

    localparam int unsigned SH_W = $clog2(OFS_W);

    logic [OFS_W-1:0] sh_q;
    logic [SH_W-1:0]  shamt;

    // Bits enter at the bottom; older bits move toward the top.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (clr_i) begin
            sh_q <= '0;
        end else if (cap_i) begin
            sh_q <= {sh_q[OFS_W-2:0], bit_i};
        end
    end

    // Move the received bits to the top; zeros fill the rest.
    assign shamt     = SH_W'(int'(OFS_W) - (int'(len_i) + 1) * int'(UNIT_W));
    assign aligned_o = sh_q << shamt;

    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (sh_q == '0)); // R2

endmodule

// File: rtl/ofl_out.sv
`timescale 1ns/1ps
module ofl_out #(
    parameter int unsigned OFS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pub_i,
    input  logic [OFS_W-1:0] word_i,
    output logic [OFS_W-1:0] ofs_word_o,
    output logic             ofs_load_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_word_o <= '0;
            ofs_load_o <= 1'b0;
        end else begin
            ofs_load_o <= pub_i;
            if (pub_i) begin
                ofs_word_o <= word_i;
            end
        end
    end

    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ofs_load_o |=> !ofs_load_o); // R5

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !ofs_load_o |-> $stable(ofs_word_o)); // R6

endmodule

// File: rtl/offset_word_loader.sv
`timescale 1ns/1ps
module offset_word_loader
    import ofl_pkg::*;
#(
    parameter int unsigned UNIT_W = OFL_UNIT_W_DEF,
    parameter int unsigned SEL_W  = OFL_SEL_W_DEF,
    localparam int unsigned OFS_W = UNIT_W * (2 ** SEL_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] len_sel,
    input  logic             ser_data,
    input  logic             ser_sync,
    output logic [OFS_W-1:0] ofs_word,
    output logic             ofs_load
);

    logic             clr;
    logic             cap;
    logic             pub;
    logic [SEL_W-1:0] len_q;
    logic [OFS_W-1:0] aligned;

    ofl_ctrl #(
        .UNIT_W (UNIT_W),
        .SEL_W  (SEL_W)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_i    (ser_sync),
        .len_sel_i (len_sel),
        .clr_o     (clr),
        .cap_o     (cap),
        .pub_o     (pub),
        .len_o     (len_q)
    );

    ofl_shift #(
        .UNIT_W (UNIT_W),
        .SEL_W  (SEL_W),
        .OFS_W  (OFS_W)
    ) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .cap_i     (cap),
        .bit_i     (ser_data),
        .len_i     (len_q),
        .aligned_o (aligned)
    );

    ofl_out #(
        .OFS_W (OFS_W)
    ) out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pub_i      (pub),
        .word_i     (aligned),
        .ofs_word_o (ofs_word),
        .ofs_load_o (ofs_load)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!ofs_load && ofs_word == '0)); // R1

endmodule

// File: tb/offset_word_loader_tb_top.sv
`timescale 1ns/1ps
module offset_word_loader_tb_top;

    localparam int SEED = 20240611;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  len_sel = 2'b00;
    logic        ser_data = 1'b0;
    logic        ser_sync = 1'b0;
    logic [31:0] ofs_word;
    logic        ofs_load;

    always #10 clk = ~clk;

    offset_word_loader dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .len_sel  (len_sel),
        .ser_data (ser_data),
        .ser_sync (ser_sync),
        .ofs_word (ofs_word),
        .ofs_load (ofs_load)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    int          cyc = 0;
    int          due_cyc = -1;
    logic [31:0] due_word = '0;
    logic [31:0] held_word = '0;
    bit          done = 1'b0;

    // R3 encoding: 00=8, 01=16, 10=24, 11=32 bits.
    function automatic int bits_of(input logic [1:0] s);
        return (int'(s) + 1) * 8;
    endfunction

    // R4: left-align the N-bit word, zero the rest.
    function automatic logic [31:0] align(input logic [1:0] s, input logic [31:0] v);
        int n;
        logic [31:0] m;
        n = bits_of(s);
        m = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
        return (v & m) << (32 - n);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: check outputs at the falling edge, then drive the inputs.
    task automatic step(input logic s, input logic d, input logic [1:0] sel, input string tag);
        @(negedge clk);
        cyc++;
        if (cyc == due_cyc) begin
            check("R5 load strobe due", {31'b0, ofs_load}, 32'd1);
            held_word = due_word;
            check("R4 published word", ofs_word, held_word);
        end else begin
            check(tag, {31'b0, ofs_load}, 32'd0);
            check("R6 word held", ofs_word, held_word);
        end
        ser_sync = s;
        ser_data = d;
        len_sel  = sel;
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'($urandom), 2'($urandom), "R6 idle no strobe");
    endtask

    // Sync plus all bits (len_sel randomized during the bits, R3).
    task automatic send_word(input logic [1:0] sel, input logic [31:0] val,
                             input logic sd, input string tag);
        int n;
        n = bits_of(sel);
        step(1'b1, sd, sel, tag);
        for (int i = 0; i < n; i++) step(1'b0, val[n-1-i], 2'($urandom), tag);
        due_cyc  = cyc + 2;
        due_word = align(sel, val);
    endtask

    // Sync plus k bits; must be followed at once by another sync (R7).
    task automatic send_partial(input logic [1:0] sel, input logic [31:0] val,
                                input int k, input string tag);
        int n;
        n = bits_of(sel);
        step(1'b1, 1'($urandom), sel, tag);
        for (int i = 0; i < k; i++) step(1'b0, val[n-1-i], 2'($urandom), tag);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        void'($urandom(SEED));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 load low in reset", {31'b0, ofs_load}, 32'd0);
        check("R1 word zero in reset", ofs_word, 32'd0);
        rst_n = 1'b1;
        @(posedge clk);

        idle(6);                                           // R6, R1

        send_word(2'b00, 32'h0000_00A5, 1'b0, "R4 len8");  idle(2);
        send_word(2'b01, 32'h0000_C396, 1'b1, "R4 len16"); idle(2);
        send_word(2'b10, 32'h00F1_7E0D, 1'b0, "R4 len24"); idle(2);
        send_word(2'b11, 32'h8000_0001, 1'b1, "R4 len32"); idle(2);

        send_word(2'b00, 32'h0000_0000, 1'b1, "R2 sync-cycle data ignored"); idle(2);
        send_word(2'b00, 32'h0000_00FF, 1'b0, "R2 msb after sync");          idle(2);

        send_word(2'b01, 32'h0000_1357, 1'b0, "R8 chain a");
        send_word(2'b10, 32'h0024_68AC, 1'b0, "R8 chain b");
        send_word(2'b00, 32'h0000_0081, 1'b0, "R8 chain c");
        idle(3);

        send_partial(2'b11, 32'hDEAD_BEEF, 10, "R7 abort mid");
        send_word(2'b00, 32'h0000_005A, 1'b0, "R7 restart");
        idle(3);
        send_partial(2'b01, 32'h0000_FFFF, 15, "R7 abort on last bit");
        send_word(2'b01, 32'h0000_1234, 1'b0, "R7 restart after last");
        idle(3);

        for (int it = 0; it < 250; it++) begin
            logic [1:0]  sel;
            logic [31:0] val;
            int          mode;
            sel  = 2'($urandom);
            val  = $urandom;
            mode = int'($urandom_range(3, 0));
            if (mode == 0) begin
                send_partial(sel, val, int'($urandom_range(bits_of(sel) - 1, 0)), "R7 random abort");
                send_word(2'($urandom), $urandom, 1'($urandom), "R7 random restart");
            end else begin
                send_word(sel, val, 1'($urandom), "R3 random word");
            end
            if (mode != 1) idle(int'($urandom_range(3, 0)));
        end
        idle(4);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

endmodule